// File: doc/BRIEF.md
# Configurable External Interrupt Controller

This block takes a number of asynchronous external interrupt lines, up to 32. A parameter sets how many lines are implemented. Each line passes through a two-flop synchroniser and then through a detector. Each line is set on its own to fire on a rising edge, a falling edge, a high level or a low level. Detected events latch into a sticky pending register. Software clears a pending bit by writing a one to the acknowledge register.

Two outputs leave the block. `irq_o` is raised whenever a pending line is also unmasked. `nmi_o` follows the pending bit of line 0 when the non-maskable path is enabled, and the mask has no effect on it. A simple 32-bit register bus reaches all registers. Reads are combinational and writes take effect on the next clock edge. The arm and disarm registers set and clear mask bits. Bits for lines that are not implemented always read zero, so software can count the lines by writing all ones to the sense register and reading it back.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `nmi_o` are low.
- R2: Writing to offset 0x00 sets the mask bits where the data bit is 1. Writing to offset 0x04 clears the mask bits where the data bit is 1. Zero data bits leave the mask unchanged. The mask reads at 0x08, and writes to 0x08 have no effect.
- R3: The sense register is at 0x14 and the edge-polarity register is at 0x18. A line with sense bit 0 is edge sensed: edge bit 1 selects rising and edge bit 0 selects falling. The opposite edge sets nothing. The pending bit becomes visible on the third rising clock edge after the input changes.
- R4: A line with sense bit 1 is level sensed, with polarity from the register at 0x1C (1 = active high, 0 = active low). Its pending bit is set on every cycle the synchronised input is active. It therefore stays set through an acknowledge until the input goes inactive.
- R5: Pending bits read at 0x0C and stay set until acknowledged. Writing a 1 to a bit at 0x10 clears that bit. If a new event hits the same bit in the same cycle, the event wins.
- R6: `irq_o` is high exactly while some bit is set in both the pending and mask registers.
- R7: Bit 0 at 0x24 enables the non-maskable path. `nmi_o` is high while that bit is 1 and line 0 is pending, whatever the mask holds.
- R8: Bits for lines at or above `NUM_LINES` read zero in every register, even after writing all ones.
- R9: The write-only offsets 0x00, 0x04 and 0x10 read zero, as does every offset that is not defined. A bus that is not selected reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Combined unmasked interrupt |
| nmi_o | output | 1 | Non-maskable interrupt from line 0 |

## Verification
A bad synchroniser or previous-value flop shows within three clocks of an input change: a pending bit appears where none belongs, or misses where one should appear, on the pending register and on `irq_o`. A wrong mask or pending bit reaches `irq_o` in the same cycle. Because pending bits are sticky, a spurious event stays visible until the bench acknowledges it. That makes the check after each stimulus decisive. A sweep over every implemented line in every one of the four sense modes shows that each mode fires only on its own condition. The same sweep also confirms that level-sensed lines resist acknowledgement while active.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_ARM    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DISARM = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SENSE  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EDGE   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_NMI    = 8'h24;

  function automatic logic [REG_W-1:0] impl_mask(int unsigned n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < REG_W; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] edge_pol_i,
  input  logic [W-1:0] lvl_pol_i,
  output logic [W-1:0] event_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_det
    logic rise, fall;
    assign rise = lvl_i[g] & ~prev_q[g];
    assign fall = ~lvl_i[g] & prev_q[g];
    always_comb begin
      if (sense_i[g]) event_o[g] = (lvl_i[g] == lvl_pol_i[g]);
      else            event_o[g] = edge_pol_i[g] ? rise : fall;
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [REG_W-1:0]  event_i,
  output logic [REG_W-1:0]  mask_o,
  output logic [REG_W-1:0]  pend_o,
  output logic [REG_W-1:0]  sense_o,
  output logic [REG_W-1:0]  edge_pol_o,
  output logic [REG_W-1:0]  lvl_pol_o,
  output logic              nmi_en_o
);
  localparam logic [REG_W-1:0] IMPL = impl_mask(NUM_LINES);

  logic wr_en;
  logic [REG_W-1:0] wval;
  logic [REG_W-1:0] mask_q, pend_q, sense_q, edge_q, lvl_q;
  logic nmi_q;

  assign wr_en = sel_i & we_i;
  assign wval  = wdata_i & IMPL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      pend_q  <= '0;
      sense_q <= '0;
      edge_q  <= '0;
      lvl_q   <= '0;
      nmi_q   <= 1'b0;
    end else begin
      if (wr_en && addr_i == OFS_ARM)    mask_q <= mask_q | wval;
      if (wr_en && addr_i == OFS_DISARM) mask_q <= mask_q & ~wval;
      if (wr_en && addr_i == OFS_SENSE)  sense_q <= wval;
      if (wr_en && addr_i == OFS_EDGE)   edge_q <= wval;
      if (wr_en && addr_i == OFS_LEVEL)  lvl_q <= wval;
      if (wr_en && addr_i == OFS_NMI)    nmi_q <= wdata_i[0];
      // new event overrides a same-cycle acknowledge
      if (wr_en && addr_i == OFS_ACK) pend_q <= ((pend_q & ~wval) | event_i) & IMPL;
      else                            pend_q <= (pend_q | event_i) & IMPL;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (addr_i)
        OFS_MASK:  rdata_o = mask_q;
        OFS_PEND:  rdata_o = pend_q;
        OFS_SENSE: rdata_o = sense_q;
        OFS_EDGE:  rdata_o = edge_q;
        OFS_LEVEL: rdata_o = lvl_q;
        OFS_NMI:   rdata_o = {{(REG_W-1){1'b0}}, nmi_q};
        default:   rdata_o = '0;
      endcase
    end
  end

  assign mask_o     = mask_q;
  assign pend_o     = pend_q;
  assign sense_o    = sense_q;
  assign edge_pol_o = edge_q;
  assign lvl_pol_o  = lvl_q;
  assign nmi_en_o   = nmi_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [REG_W-1:0]     bus_wdata_i,
  output logic [REG_W-1:0]     bus_rdata_o,
  output logic                 irq_o,
  output logic                 nmi_o
);
  logic [NUM_LINES-1:0] sync_n;
  logic [REG_W-1:0] sync_w, event_w, mask_w, pend_w, sense_w, edge_w, lvl_w;
  logic nmi_en_w;

  irq_sync #(.W(NUM_LINES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (line_i),
    .sync_o  (sync_n)
  );

  always_comb begin
    sync_w = '0;
    sync_w[NUM_LINES-1:0] = sync_n;
  end

  irq_detect #(.W(REG_W)) u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (sync_w),
    .sense_i    (sense_w),
    .edge_pol_i (edge_w),
    .lvl_pol_i  (lvl_w),
    .event_o    (event_w)
  );

  irq_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (bus_sel_i),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .event_i    (event_w),
    .mask_o     (mask_w),
    .pend_o     (pend_w),
    .sense_o    (sense_w),
    .edge_pol_o (edge_w),
    .lvl_pol_o  (lvl_w),
    .nmi_en_o   (nmi_en_w)
  );

  assign irq_o = |(pend_w & mask_w);
  assign nmi_o = nmi_en_w & pend_w[0];
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [REG_W-1:0]  bus_wdata_i,
  input logic [REG_W-1:0]  event_w,
  input logic [REG_W-1:0]  mask_w,
  input logic [REG_W-1:0]  pend_w,
  input logic              irq_o,
  input logic              nmi_o
);
  localparam logic [REG_W-1:0] IMPL = impl_mask(NUM_LINES);

  logic wr_arm, wr_disarm, wr_ack, wr_nmi;
  assign wr_arm    = bus_sel_i && bus_we_i && bus_addr_i == OFS_ARM;
  assign wr_disarm = bus_sel_i && bus_we_i && bus_addr_i == OFS_DISARM;
  assign wr_ack    = bus_sel_i && bus_we_i && bus_addr_i == OFS_ACK;
  assign wr_nmi    = bus_sel_i && bus_we_i && bus_addr_i == OFS_NMI;

  for (genvar k = 0; k < REG_W; k++) begin : g_bit
    AST_EVENT_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_w[k] |=> pend_w[k]); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ack && bus_wdata_i[k] && !event_w[k]) |=> !pend_w[k]); // R5
    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_w[k] && !wr_ack) |=> pend_w[k]); // R5
    AST_ARM_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_arm && bus_wdata_i[k] && IMPL[k]) |=> mask_w[k]); // R2
    AST_DISARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_disarm && bus_wdata_i[k]) |=> !mask_w[k]); // R2
  end

  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_w | mask_w) & ~IMPL) == '0); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (pend_w != $past(pend_w)) || (mask_w != $past(mask_w))); // R6
  AST_NMI_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_nmi && !bus_wdata_i[0]) |=> !nmi_o); // R7
endmodule

bind ext_irq_ctrl ext_irq_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .event_w     (event_w),
  .mask_w      (mask_w),
  .pend_w      (pend_w),
  .irq_o       (irq_o),
  .nmi_o       (nmi_o)
);

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 5;
  localparam logic [31:0] IMPL = (32'd1 << NL) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic sel = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, nmi;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(NL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(lines),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .nmi_o(nmi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a[7:0], d);
    chk(req, d, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    foreach (d[i]) if (i < 10) rd_chk("R1 reset read", 32'(i * 4), 32'h0);
    chk("R1 irq_o", {31'b0, irq}, 0);
    chk("R1 nmi_o", {31'b0, nmi}, 0);

    // R8: unimplemented bits
    bus_wr(8'h14, 32'hFFFF_FFFF); rd_chk("R8 sense width", 8'h14, IMPL);
    bus_wr(8'h18, 32'hFFFF_FFFF); rd_chk("R8 edge width", 8'h18, IMPL);
    bus_wr(8'h1C, 32'hFFFF_FFFF); rd_chk("R8 level width", 8'h1C, IMPL);
    bus_wr(8'h00, 32'hFFFF_FFFF); rd_chk("R8 mask width", 8'h08, IMPL);
    bus_wr(8'h14, 0); bus_wr(8'h18, 0); bus_wr(8'h1C, 0);
    bus_wr(8'h04, 32'hFFFF_FFFF); rd_chk("R2 disarm all", 8'h08, 0);

    // R2: set/clear semantics
    bus_wr(8'h00, 32'h05); bus_wr(8'h00, 32'h08); rd_chk("R2 arm accumulate", 8'h08, 32'h0D);
    bus_wr(8'h04, 32'h04); rd_chk("R2 disarm one", 8'h08, 32'h09);
    bus_wr(8'h08, 32'hFFFF_FFFF); rd_chk("R2 mask offset ignored", 8'h08, 32'h09);
    bus_wr(8'h04, 32'hFFFF_FFFF);

    // R9: write-only and undefined offsets
    bus_wr(8'h00, 32'h1F);
    rd_chk("R9 arm reads zero", 8'h00, 0);
    rd_chk("R9 disarm reads zero", 8'h04, 0);
    rd_chk("R9 ack reads zero", 8'h10, 0);
    rd_chk("R9 offset 0x20", 8'h20, 0);
    rd_chk("R9 offset 0x28", 8'h28, 0);
    rd_chk("R9 offset 0xFC", 8'hFC, 0);
    bus_wr(8'h04, 32'h1F);

    // R3: latency of a rising edge on line 2
    bus_wr(8'h18, 32'h04); bus_wr(8'h00, 32'h04); settle(); bus_wr(8'h10, 32'h1F);
    @(negedge clk); lines[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3 not yet after two edges", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R3 visible after third edge", {31'b0, irq}, 1);
    lines[2] = 1'b0; settle(); bus_wr(8'h10, 32'h1F); bus_wr(8'h04, 32'h1F);

    // Sweep: every line in every sense mode (R3 R4 R5 R6)
    for (int i = 0; i < NL; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic act;
        logic [31:0] bit_i;
        bit_i = 32'd1 << i;
        act = (m == 0 || m == 2);
        bus_wr(8'h14, (m >= 2) ? bit_i : 0);
        bus_wr(8'h18, (m == 0) ? bit_i : 0);
        bus_wr(8'h1C, (m == 2) ? bit_i : 0);
        lines = '0; lines[i] = ~act;
        settle();
        bus_wr(8'h10, 32'hFFFF_FFFF);
        bus_wr(8'h04, 32'hFFFF_FFFF);
        bus_wr(8'h00, bit_i);
        rd_chk($sformatf("R3 R4 idle quiet line %0d mode %0d", i, m), 8'h0C, 0);
        chk("R6 irq low when idle", {31'b0, irq}, 0);
        lines[i] = act;
        settle();
        rd_chk($sformatf("R3 R4 event line %0d mode %0d", i, m), 8'h0C, bit_i);
        chk("R6 irq high when pending and armed", {31'b0, irq}, 1);
        bus_wr(8'h10, bit_i);
        if (m < 2) begin
          rd_chk("R5 ack clears edge pending", 8'h0C, 0);
          lines[i] = ~act;
          settle();
          rd_chk($sformatf("R3 opposite edge ignored line %0d", i), 8'h0C, 0);
        end else begin
          rd_chk("R4 R5 ack blocked while active", 8'h0C, bit_i);
          lines[i] = ~act;
          settle();
          rd_chk("R4 pending latched after release", 8'h0C, bit_i);
          bus_wr(8'h10, bit_i);
          rd_chk("R4 ack after release", 8'h0C, 0);
        end
        chk("R6 irq low after ack", {31'b0, irq}, 0);
      end
    end

    // R6: pending but masked
    bus_wr(8'h14, 32'h02); bus_wr(8'h1C, 32'h02); bus_wr(8'h04, 32'h1F);
    lines = 5'b00010; settle();
    chk("R6 masked pending keeps irq low", {31'b0, irq}, 0);
    bus_wr(8'h00, 32'h02);
    chk("R6 arm raises irq", {31'b0, irq}, 1);
    lines = '0; settle(); bus_wr(8'h10, 32'h1F); bus_wr(8'h04, 32'h1F);

    // R7: non-maskable path from line 0
    bus_wr(8'h14, 32'h01); bus_wr(8'h1C, 32'h01);
    lines = 5'b00001; settle();
    chk("R7 nmi off while disabled", {31'b0, nmi}, 0);
    bus_wr(8'h24, 32'h1);
    rd_chk("R7 nmi control reads back", 8'h24, 1);
    chk("R7 nmi high regardless of mask", {31'b0, nmi}, 1);
    chk("R7 irq stays low when masked", {31'b0, irq}, 0);
    bus_wr(8'h24, 32'h0);
    chk("R7 nmi drops when disabled", {31'b0, nmi}, 0);
    lines = '0; settle(); bus_wr(8'h10, 32'h1F);
    bus_wr(8'h24, 32'h1);
    chk("R7 nmi low with nothing pending", {31'b0, nmi}, 0);

    finish_run();
  end
endmodule